// File: doc/BRIEF.md
# Processor Trap Entry Controller

This block performs trap entry for a 32-bit soft processor core. Each cycle it looks at four possible events: a memory-management fault, a general hardware exception, a hardware break and an external interrupt request. It picks at most one of them and, on the next clock edge, presents everything the core needs to enter the handler. That is the new program counter, a register-file write that saves the return address, an updated machine status word, and new values for the exception status, exception address and branch target registers. For one cycle it also raises the strobes that drop the load reservation and wipe the instruction-context flags.

The core supplies its current PC, its status word and its instruction context: delay slot, immediate prefix, and whether the pending branch used an immediate prefix. The block works out where execution resumes. An interrupt or break returns to the interrupted instruction. A hardware exception returns past it. A memory fault rewinds so that an interrupted branch or prefix pair runs again. Any event that enters a handler saves the translation and user-mode bits into their shadow positions and then clears them.

Top module: `trap_entry_ctrl`

## Requirements
- R1: An interrupt is taken only when `irq_i` is high, status bit 1 (interrupt enable) is set, status bits 9 (exception in progress) and 3 (break in progress) are clear, and neither `in_dslot_i` nor `after_imm_i` is set.
- R2: Interrupt entry sets `next_pc_o` to VEC_BASE+0x10, writes `pc_i` into register 14 and clears status bit 1.
- R3: Break entry sets `next_pc_o` to VEC_BASE+0x18, writes `pc_i` into register 16 and sets status bit 3.
- R4: Hardware exception entry sets `next_pc_o` to VEC_BASE+0x20, writes `pc_i`+4 into register 17, sets status bit 9, and loads the exception status with `hwx_code_i` in bits [4:0] and zeros elsewhere.
- R5: With HAS_EXC=0 a hardware exception request is ignored: no entry is taken and the exception status is unchanged.
- R6: Memory-fault entry sets `next_pc_o` to VEC_BASE+0x20, sets status bit 9, and writes into register 17 `pc_i`-8 when in a delay slot whose branch used an immediate prefix, `pc_i`-4 in any other delay slot or after an immediate prefix, and `pc_i` otherwise.
- R7: A memory fault loads exception status bits [4:0] with 16 (data protection), 17 (fetch protection), 18 (data miss) or 19 (fetch miss), sets bit 10 for a store, and loads `mmu_addr_i` into the exception address register.
- R8: On both exception kinds, exception status bit 12 is set exactly when `in_dslot_i` is set, and in that case the branch target register takes `btarget_i`; otherwise the branch target register keeps its value.
- R9: On every entry, status bits 13 and 11 (translation and user mode) are copied into bits 14 and 12 and then cleared.
- R10: `taken_o`, `rf_we_o`, `msr_we_o`, `resv_clr_o` and `ctx_clr_o` are high for exactly the cycle after an accepted event and low after reset; all data outputs reset to zero.
- R11: An unaligned-data hardware exception loads the exception status with code 1 in bits [4:0] and `hwx_synd_i` in bits [11:5], and loads `hwx_addr_i` into the exception address register.
- R12: Events pending in the same cycle are resolved by the fixed priority memory fault, hardware exception, break, interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | PC of the current instruction |
| msr_i | input | 32 | Current machine status word |
| in_dslot_i | input | 1 | Current instruction sits in a delay slot |
| after_imm_i | input | 1 | Current instruction follows an immediate prefix |
| branch_imm_i | input | 1 | The pending branch used an immediate prefix |
| btarget_i | input | 32 | Pending branch target |
| irq_i | input | 1 | External interrupt request |
| brk_i | input | 1 | Hardware break request |
| hwx_i | input | 1 | Hardware exception request |
| hwx_unaligned_i | input | 1 | Hardware exception is an unaligned data access |
| hwx_code_i | input | 5 | Cause code of a non-unaligned hardware exception |
| hwx_synd_i | input | 7 | Per-instruction syndrome bits for unaligned access |
| hwx_addr_i | input | 32 | Offending address of an unaligned access |
| mmu_i | input | 1 | Memory-management fault |
| mmu_miss_i | input | 1 | Fault is a translation miss (0: protection) |
| mmu_fetch_i | input | 1 | Faulting access was an instruction fetch |
| mmu_store_i | input | 1 | Faulting access was a store |
| mmu_addr_i | input | 32 | Faulting address |
| taken_o | output | 1 | Entry performed (one-cycle pulse) |
| next_pc_o | output | 32 | Handler vector address |
| rf_we_o | output | 1 | Register-file write enable for the return address |
| rf_idx_o | output | 5 | Register index receiving the return address |
| rf_data_o | output | 32 | Return address |
| msr_we_o | output | 1 | Status word write enable |
| msr_o | output | 32 | New status word |
| esr_o | output | 32 | Exception status register |
| ear_o | output | 32 | Exception address register |
| btr_o | output | 32 | Branch target register |
| resv_clr_o | output | 1 | Invalidate the load reservation |
| ctx_clr_o | output | 1 | Clear instruction-context flags |

## Verification
The bench goes after the rewind of the memory-fault return address in all three context combinations. A design that mixed up the prefixed and plain delay-slot cases would hand back an address 4 bytes off. It also sends every interrupt blocker on its own. A qualifier left out of the interrupt gate would let an interrupt break into a handler or split a branch from its delay slot. Simultaneous events check the priority order, since a wrong order vectors to the wrong handler and saves the return address in the wrong register. The status word is driven with the mode bits set, so a shift in the wrong direction or by the wrong amount shows up as corrupted interrupt or in-progress bits. A second instance with the exception feature removed shows that a hardware exception then leaves the exception status alone.

// File: rtl/trap_pkg.sv
package trap_pkg;

   typedef enum logic [2:0] {
      EV_NONE = 3'd0,
      EV_IRQ  = 3'd1,
      EV_BRK  = 3'd2,
      EV_HWX  = 3'd3,
      EV_MMU  = 3'd4
   } trap_ev_e;

   // status word bit positions (shadow = live + 1)
   localparam int ST_IE  = 1;
   localparam int ST_BIP = 3;
   localparam int ST_EIP = 9;
   localparam int ST_UM  = 11;
   localparam int ST_UMS = 12;
   localparam int ST_VM  = 13;
   localparam int ST_VMS = 14;
   localparam int ST_TOP = ST_VMS;

   // exception status layout
   localparam int XS_CODE_W = 5;
   localparam int XS_SYN_LSB = 5;
   localparam int XS_SYN_W = 7;
   localparam int XS_STORE = 10;
   localparam int XS_DS = 12;

   localparam logic [XS_CODE_W-1:0] CODE_UNALIGN  = 5'd1;
   localparam logic [XS_CODE_W-1:0] CODE_MMU_BASE = 5'd16;

   // handler vector offsets
   localparam int OFS_IRQ = 'h10;
   localparam int OFS_BRK = 'h18;
   localparam int OFS_EXC = 'h20;

   // return-address register indexes
   localparam int RIDX_IRQ = 14;
   localparam int RIDX_BRK = 16;
   localparam int RIDX_EXC = 17;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter bit HAS_EXC = 1'b1
) (
   input  logic     irq_i,
   input  logic     brk_i,
   input  logic     hwx_i,
   input  logic     mmu_i,
   input  logic     st_ie_i,
   input  logic     st_eip_i,
   input  logic     st_bip_i,
   input  logic     in_dslot_i,
   input  logic     after_imm_i,
   output trap_ev_e ev_o
);

   logic hwx_live;
   logic irq_ok;

   generate
      if (HAS_EXC) begin : g_exc_on
         assign hwx_live = hwx_i;
      end else begin : g_exc_off
         assign hwx_live = 1'b0;
      end
   endgenerate

   assign irq_ok = irq_i & st_ie_i & ~st_eip_i & ~st_bip_i
                 & ~in_dslot_i & ~after_imm_i;

   always_comb begin
      if (mmu_i)         ev_o = EV_MMU;
      else if (hwx_live) ev_o = EV_HWX;
      else if (brk_i)    ev_o = EV_BRK;
      else if (irq_ok)   ev_o = EV_IRQ;
      else               ev_o = EV_NONE;
   end

endmodule

// File: rtl/trap_retaddr.sv
module trap_retaddr
   import trap_pkg::*;
#(
   parameter int               XLEN     = 32,
   parameter int               IDX_W    = 5,
   parameter logic [XLEN-1:0]  VEC_BASE = '0
) (
   input  trap_ev_e         ev_i,
   input  logic [XLEN-1:0]  pc_i,
   input  logic             in_dslot_i,
   input  logic             after_imm_i,
   input  logic             branch_imm_i,
   output logic [XLEN-1:0]  vec_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [XLEN-1:0]  data_o
);

   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   logic [XLEN-1:0] rewind;

   always_comb begin
      if (in_dslot_i)
         rewind = branch_imm_i ? (STEP << 1) : STEP;
      else if (after_imm_i)
         rewind = STEP;
      else
         rewind = '0;
   end

   always_comb begin
      vec_o  = VEC_BASE;
      idx_o  = '0;
      data_o = pc_i;
      unique case (ev_i)
         EV_IRQ: begin
            vec_o = VEC_BASE + XLEN'(OFS_IRQ);
            idx_o = IDX_W'(RIDX_IRQ);
         end
         EV_BRK: begin
            vec_o = VEC_BASE + XLEN'(OFS_BRK);
            idx_o = IDX_W'(RIDX_BRK);
         end
         EV_HWX: begin
            vec_o  = VEC_BASE + XLEN'(OFS_EXC);
            idx_o  = IDX_W'(RIDX_EXC);
            data_o = pc_i + STEP;
         end
         EV_MMU: begin
            vec_o  = VEC_BASE + XLEN'(OFS_EXC);
            idx_o  = IDX_W'(RIDX_EXC);
            data_o = pc_i - rewind;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/trap_status.sv
module trap_status
   import trap_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  trap_ev_e                ev_i,
   input  logic [XLEN-1:0]         msr_i,
   input  logic                    in_dslot_i,
   input  logic [XLEN-1:0]         btarget_i,
   input  logic                    hwx_unaligned_i,
   input  logic [XS_CODE_W-1:0]    hwx_code_i,
   input  logic [XS_SYN_W-1:0]     hwx_synd_i,
   input  logic [XLEN-1:0]         hwx_addr_i,
   input  logic                    mmu_miss_i,
   input  logic                    mmu_fetch_i,
   input  logic                    mmu_store_i,
   input  logic [XLEN-1:0]         mmu_addr_i,
   input  logic [XLEN-1:0]         esr_q_i,
   input  logic [XLEN-1:0]         ear_q_i,
   input  logic [XLEN-1:0]         btr_q_i,
   output logic [XLEN-1:0]         msr_o,
   output logic [XLEN-1:0]         esr_o,
   output logic [XLEN-1:0]         ear_o,
   output logic [XLEN-1:0]         btr_o
);

   localparam int NPAIR = 2;
   localparam int LIVE_POS [NPAIR] = '{ST_UM, ST_VM};

   logic is_exc;
   logic [XLEN-1:0] msr_ev;
   logic [XLEN-1:0] msr_mode;

   assign is_exc = (ev_i == EV_HWX) || (ev_i == EV_MMU);

   // event-specific in-progress / enable bits and syndrome
   always_comb begin
      msr_ev = msr_i;
      esr_o  = esr_q_i;
      ear_o  = ear_q_i;
      btr_o  = btr_q_i;
      unique case (ev_i)
         EV_IRQ: msr_ev[ST_IE] = 1'b0;
         EV_BRK: msr_ev[ST_BIP] = 1'b1;
         EV_HWX: begin
            msr_ev[ST_EIP] = 1'b1;
            esr_o = '0;
            if (hwx_unaligned_i) begin
               esr_o[XS_CODE_W-1:0] = CODE_UNALIGN;
               esr_o[XS_SYN_LSB +: XS_SYN_W] = hwx_synd_i;
               ear_o = hwx_addr_i;
            end else begin
               esr_o[XS_CODE_W-1:0] = hwx_code_i;
            end
         end
         EV_MMU: begin
            msr_ev[ST_EIP] = 1'b1;
            esr_o = '0;
            esr_o[XS_CODE_W-1:0] = CODE_MMU_BASE
                                 | {3'b000, mmu_miss_i, mmu_fetch_i};
            esr_o[XS_STORE] = mmu_store_i;
            ear_o = mmu_addr_i;
         end
         default: ;
      endcase
      if (is_exc) begin
         esr_o[XS_DS] = in_dslot_i;
         if (in_dslot_i)
            btr_o = btarget_i;
      end
   end

   // save translation/user mode into shadow bits, then drop them
   generate
      for (genvar p = 0; p < NPAIR; p++) begin : g_mode
         localparam int LP = LIVE_POS[p];
         assign msr_mode[LP + 1] = (ev_i != EV_NONE) ? msr_i[LP] : msr_ev[LP + 1];
         assign msr_mode[LP]     = (ev_i != EV_NONE) ? 1'b0      : msr_ev[LP];
      end
      for (genvar b = 0; b < XLEN; b++) begin : g_pass
         if (b != ST_UM && b != ST_UMS && b != ST_VM && b != ST_VMS) begin : g_keep
            assign msr_mode[b] = msr_ev[b];
         end
      end
   endgenerate

   assign msr_o = msr_mode;

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
   import trap_pkg::*;
#(
   parameter int               XLEN     = 32,
   parameter int               IDX_W    = 5,
   parameter logic [XLEN-1:0]  VEC_BASE = 32'h0000_1000,
   parameter bit               HAS_EXC  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [XLEN-1:0]  pc_i,
   input  logic [XLEN-1:0]  msr_i,
   input  logic             in_dslot_i,
   input  logic             after_imm_i,
   input  logic             branch_imm_i,
   input  logic [XLEN-1:0]  btarget_i,
   input  logic             irq_i,
   input  logic             brk_i,
   input  logic             hwx_i,
   input  logic             hwx_unaligned_i,
   input  logic [4:0]       hwx_code_i,
   input  logic [6:0]       hwx_synd_i,
   input  logic [XLEN-1:0]  hwx_addr_i,
   input  logic             mmu_i,
   input  logic             mmu_miss_i,
   input  logic             mmu_fetch_i,
   input  logic             mmu_store_i,
   input  logic [XLEN-1:0]  mmu_addr_i,
   output logic             taken_o,
   output logic [XLEN-1:0]  next_pc_o,
   output logic             rf_we_o,
   output logic [IDX_W-1:0] rf_idx_o,
   output logic [XLEN-1:0]  rf_data_o,
   output logic             msr_we_o,
   output logic [XLEN-1:0]  msr_o,
   output logic [XLEN-1:0]  esr_o,
   output logic [XLEN-1:0]  ear_o,
   output logic [XLEN-1:0]  btr_o,
   output logic             resv_clr_o,
   output logic             ctx_clr_o
);

   localparam int MIN_XLEN = ST_TOP + 1;
   localparam int VEC_ALIGN = OFS_EXC * 2;

   generate
      if (XLEN < MIN_XLEN || XLEN < XS_DS + 1) begin : g_bad_xlen
         $error("trap_entry_ctrl: XLEN too narrow for status layout");
      end
      if ((1 << IDX_W) <= RIDX_EXC) begin : g_bad_idx
         $error("trap_entry_ctrl: IDX_W cannot address the link registers");
      end
      if ((VEC_BASE % VEC_ALIGN) != 0) begin : g_bad_vec
         $error("trap_entry_ctrl: VEC_BASE must be aligned to the vector table");
      end
   endgenerate

   trap_ev_e ev;
   logic [XLEN-1:0]  vec_n, rdata_n, msr_n, esr_n, ear_n, btr_n;
   logic [IDX_W-1:0] idx_n;
   logic             pulse_q;

   trap_arbiter #(.HAS_EXC(HAS_EXC)) u_arb (
      .irq_i       (irq_i),
      .brk_i       (brk_i),
      .hwx_i       (hwx_i),
      .mmu_i       (mmu_i),
      .st_ie_i     (msr_i[ST_IE]),
      .st_eip_i    (msr_i[ST_EIP]),
      .st_bip_i    (msr_i[ST_BIP]),
      .in_dslot_i  (in_dslot_i),
      .after_imm_i (after_imm_i),
      .ev_o        (ev)
   );

   trap_retaddr #(.XLEN(XLEN), .IDX_W(IDX_W), .VEC_BASE(VEC_BASE)) u_ret (
      .ev_i         (ev),
      .pc_i         (pc_i),
      .in_dslot_i   (in_dslot_i),
      .after_imm_i  (after_imm_i),
      .branch_imm_i (branch_imm_i),
      .vec_o        (vec_n),
      .idx_o        (idx_n),
      .data_o       (rdata_n)
   );

   trap_status #(.XLEN(XLEN)) u_st (
      .ev_i            (ev),
      .msr_i           (msr_i),
      .in_dslot_i      (in_dslot_i),
      .btarget_i       (btarget_i),
      .hwx_unaligned_i (hwx_unaligned_i),
      .hwx_code_i      (hwx_code_i),
      .hwx_synd_i      (hwx_synd_i),
      .hwx_addr_i      (hwx_addr_i),
      .mmu_miss_i      (mmu_miss_i),
      .mmu_fetch_i     (mmu_fetch_i),
      .mmu_store_i     (mmu_store_i),
      .mmu_addr_i      (mmu_addr_i),
      .esr_q_i         (esr_o),
      .ear_q_i         (ear_o),
      .btr_q_i         (btr_o),
      .msr_o           (msr_n),
      .esr_o           (esr_n),
      .ear_o           (ear_n),
      .btr_o           (btr_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_q   <= 1'b0;
         next_pc_o <= '0;
         rf_idx_o  <= '0;
         rf_data_o <= '0;
         msr_o     <= '0;
         esr_o     <= '0;
         ear_o     <= '0;
         btr_o     <= '0;
      end else begin
         pulse_q <= (ev != EV_NONE);
         if (ev != EV_NONE) begin
            next_pc_o <= vec_n;
            rf_idx_o  <= idx_n;
            rf_data_o <= rdata_n;
            msr_o     <= msr_n;
            esr_o     <= esr_n;
            ear_o     <= ear_n;
            btr_o     <= btr_n;
         end
      end
   end

   assign taken_o    = pulse_q;
   assign rf_we_o    = pulse_q;
   assign msr_we_o   = pulse_q;
   assign resv_clr_o = pulse_q;
   assign ctx_clr_o  = pulse_q;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
   parameter int               XLEN     = 32,
   parameter int               IDX_W    = 5,
   parameter logic [XLEN-1:0]  VEC_BASE = '0,
   parameter bit               HAS_EXC  = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_i,
   input logic             brk_i,
   input logic             hwx_i,
   input logic             mmu_i,
   input logic [XLEN-1:0]  msr_i,
   input logic             in_dslot_i,
   input logic [XLEN-1:0]  btarget_i,
   input logic             taken_o,
   input logic [XLEN-1:0]  next_pc_o,
   input logic [IDX_W-1:0] rf_idx_o,
   input logic [XLEN-1:0]  msr_o,
   input logic [XLEN-1:0]  esr_o,
   input logic [XLEN-1:0]  btr_o
);

   // R1
   irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_i && !msr_i[1] && !brk_i && !hwx_i && !mmu_i) |=> !taken_o);

   // R12
   mmu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mmu_i |=> (taken_o && rf_idx_o == IDX_W'(17) && next_pc_o == VEC_BASE + XLEN'('h20)));

   // R3
   brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_i && !hwx_i && !mmu_i) |=> (taken_o && msr_o[3] && rf_idx_o == IDX_W'(16)));

   // R9
   mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taken_o |-> (!msr_o[11] && !msr_o[13]));

   // R10
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_i || brk_i || hwx_i || mmu_i) |=> !taken_o);

   // R5
   exc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!HAS_EXC && hwx_i && !mmu_i && !brk_i && !irq_i) |=> (!taken_o && $stable(esr_o)));

   // R8
   dslot_btr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mmu_i && in_dslot_i) |=> (esr_o[12] && btr_o == $past(btarget_i)));

endmodule

bind trap_entry_ctrl trap_entry_chk #(
   .XLEN(XLEN), .IDX_W(IDX_W), .VEC_BASE(VEC_BASE), .HAS_EXC(HAS_EXC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_i      (irq_i),
   .brk_i      (brk_i),
   .hwx_i      (hwx_i),
   .mmu_i      (mmu_i),
   .msr_i      (msr_i),
   .in_dslot_i (in_dslot_i),
   .btarget_i  (btarget_i),
   .taken_o    (taken_o),
   .next_pc_o  (next_pc_o),
   .rf_idx_o   (rf_idx_o),
   .msr_o      (msr_o),
   .esr_o      (esr_o),
   .btr_o      (btr_o)
);

// File: tb/trap_entry_ctrl_test.sv
`timescale 1ns/1ps
module trap_entry_ctrl_test;

   localparam logic [31:0] VB = 32'h0000_1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [31:0] pc, msr, btarget, hwx_addr, mmu_addr;
   logic dslot, aimm, bimm;
   logic irq, brk, hwx, hwx_un, mmu, m_miss, m_fetch, m_store;
   logic [4:0] hwx_code;
   logic [6:0] hwx_synd;

   logic taken, rf_we, msr_we, resv_clr, ctx_clr;
   logic [31:0] npc, rdata, msr_out, esr, ear, btr;
   logic [4:0] ridx;
   logic nx_taken, nx_we, nx_mwe, nx_rc, nx_cc;
   logic [31:0] nx_npc, nx_rdata, nx_msr, nx_esr, nx_ear, nx_btr;
   logic [4:0] nx_idx;

   trap_entry_ctrl #(.VEC_BASE(VB), .HAS_EXC(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .pc_i(pc), .msr_i(msr), .in_dslot_i(dslot),
      .after_imm_i(aimm), .branch_imm_i(bimm), .btarget_i(btarget),
      .irq_i(irq), .brk_i(brk), .hwx_i(hwx), .hwx_unaligned_i(hwx_un),
      .hwx_code_i(hwx_code), .hwx_synd_i(hwx_synd), .hwx_addr_i(hwx_addr),
      .mmu_i(mmu), .mmu_miss_i(m_miss), .mmu_fetch_i(m_fetch),
      .mmu_store_i(m_store), .mmu_addr_i(mmu_addr),
      .taken_o(taken), .next_pc_o(npc), .rf_we_o(rf_we), .rf_idx_o(ridx),
      .rf_data_o(rdata), .msr_we_o(msr_we), .msr_o(msr_out), .esr_o(esr),
      .ear_o(ear), .btr_o(btr), .resv_clr_o(resv_clr), .ctx_clr_o(ctx_clr)
   );

   trap_entry_ctrl #(.VEC_BASE(VB), .HAS_EXC(1'b0)) u_noexc (
      .clk(clk), .rst_n(rst_n), .pc_i(pc), .msr_i(msr), .in_dslot_i(dslot),
      .after_imm_i(aimm), .branch_imm_i(bimm), .btarget_i(btarget),
      .irq_i(irq), .brk_i(brk), .hwx_i(hwx), .hwx_unaligned_i(hwx_un),
      .hwx_code_i(hwx_code), .hwx_synd_i(hwx_synd), .hwx_addr_i(hwx_addr),
      .mmu_i(mmu), .mmu_miss_i(m_miss), .mmu_fetch_i(m_fetch),
      .mmu_store_i(m_store), .mmu_addr_i(mmu_addr),
      .taken_o(nx_taken), .next_pc_o(nx_npc), .rf_we_o(nx_we), .rf_idx_o(nx_idx),
      .rf_data_o(nx_rdata), .msr_we_o(nx_mwe), .msr_o(nx_msr), .esr_o(nx_esr),
      .ear_o(nx_ear), .btr_o(nx_btr), .resv_clr_o(nx_rc), .ctx_clr_o(nx_cc)
   );

   int n_chk = 0;
   int n_fail = 0;

   // reference state for the main instance
   logic [31:0] m_esr = 0, m_ear = 0, m_btr = 0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic clear_events();
      irq = 0; brk = 0; hwx = 0; mmu = 0;
      hwx_un = 0; m_miss = 0; m_fetch = 0; m_store = 0;
   endtask

   // apply current inputs for one clock, compare against the model
   task automatic step(string req);
      int kind;       // 0 none, 1 irq, 2 brk, 3 hwx, 4 mmu
      int kind_nx;
      bit irq_ok;
      logic [31:0] e_pc, e_data, e_msr;
      logic [4:0]  e_idx;
      logic [31:0] nx_esr_before;
      irq_ok = irq && msr[1] && !msr[9] && !msr[3] && !dslot && !aimm;
      kind = mmu ? 4 : hwx ? 3 : brk ? 2 : irq_ok ? 1 : 0;
      kind_nx = mmu ? 4 : brk ? 2 : irq_ok ? 1 : 0;
      nx_esr_before = nx_esr;
      e_msr = msr;
      e_pc = 0; e_data = 0; e_idx = 0;
      case (kind)
         1: begin e_pc = VB + 32'h10; e_idx = 14; e_data = pc; e_msr[1] = 0; end
         2: begin e_pc = VB + 32'h18; e_idx = 16; e_data = pc; e_msr[3] = 1; end
         3: begin
            e_pc = VB + 32'h20; e_idx = 17; e_data = pc + 4; e_msr[9] = 1;
            if (hwx_un) begin
               m_esr = 32'd1 + (32'(hwx_synd) * 32);
               m_ear = hwx_addr;
            end else m_esr = 32'(hwx_code);
         end
         4: begin
            e_pc = VB + 32'h20; e_idx = 17; e_msr[9] = 1;
            if (dslot && bimm) e_data = pc - 8;
            else if (dslot || aimm) e_data = pc - 4;
            else e_data = pc;
            m_esr = 16 + (m_miss ? 2 : 0) + (m_fetch ? 1 : 0) + (m_store ? 1024 : 0);
            m_ear = mmu_addr;
         end
         default: ;
      endcase
      if (kind >= 3) begin
         if (dslot) begin m_esr = m_esr + 4096; m_btr = btarget; end
      end
      if (kind != 0) begin
         e_msr[14] = msr[13]; e_msr[12] = msr[11];
         e_msr[13] = 0; e_msr[11] = 0;
      end
      @(negedge clk);
      chk(req, "taken", 32'(taken), 32'(kind != 0));
      if (kind != 0) begin
         chk(req, "next_pc", npc, e_pc);
         chk(req, "rf_idx", 32'(ridx), 32'(e_idx));
         chk(req, "rf_data", rdata, e_data);
         chk(req, "msr", msr_out, e_msr);
         chk("R10", "strobes", {27'b0, rf_we, msr_we, resv_clr, ctx_clr, taken}, 32'h1f);
      end else begin
         chk("R10", "strobes", {27'b0, rf_we, msr_we, resv_clr, ctx_clr, taken}, 32'h0);
      end
      chk(req, "esr", esr, m_esr);
      chk(req, "ear", ear, m_ear);
      chk(req, "btr", btr, m_btr);
      chk(kind != kind_nx ? "R5" : req, "noexc taken", 32'(nx_taken), 32'(kind_nx != 0));
      if (kind_nx == 0) chk("R5", "noexc esr held", nx_esr, nx_esr_before);
      clear_events();
      dslot = 0; aimm = 0; bimm = 0;
   endtask

   initial begin
      #(4 * 100000);
      n_fail++; n_chk++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      clear_events();
      pc = 32'h0000_8000; msr = 0; btarget = 32'h0000_4440;
      hwx_addr = 0; mmu_addr = 0; hwx_code = 0; hwx_synd = 0;
      dslot = 0; aimm = 0; bimm = 0;
      repeat (3) @(negedge clk);
      // R10 reset values
      chk("R10", "reset taken", 32'(taken), 0);
      chk("R10", "reset msr", msr_out, 0);
      chk("R10", "reset esr", esr, 0);
      chk("R10", "reset next_pc", npc, 0);
      rst_n = 1;
      step("R10");

      // R2 interrupt accepted
      msr = 32'h0000_0002; pc = 32'h0000_8010; irq = 1; step("R2");
      // R1 each blocker on its own
      msr = 32'h0000_0000; irq = 1; step("R1");
      msr = 32'h0000_0202; irq = 1; step("R1");
      msr = 32'h0000_000a; irq = 1; step("R1");
      msr = 32'h0000_0002; irq = 1; dslot = 1; step("R1");
      msr = 32'h0000_0002; irq = 1; aimm = 1; step("R1");

      // R3 break, R9 mode save with both modes on
      msr = 32'h0000_2802; pc = 32'h0000_9000; brk = 1; step("R3");
      msr = 32'h0000_0800; brk = 1; step("R9");

      // R4 plain hardware exception
      msr = 32'h0000_2000; pc = 32'h0000_a000; hwx = 1; hwx_code = 5'd7; step("R4");
      // R11 unaligned, R8 in delay slot
      msr = 32'h0000_0002; hwx = 1; hwx_un = 1; hwx_synd = 7'h55;
      hwx_addr = 32'h0000_a003; step("R11");
      hwx = 1; hwx_code = 5'd3; dslot = 1; btarget = 32'h0000_b0b0; step("R8");

      // R6 rewind cases, R7 codes
      pc = 32'h0000_c000; mmu_addr = 32'h1234_5678;
      mmu = 1; step("R6");
      mmu = 1; aimm = 1; m_fetch = 1; step("R6");
      mmu = 1; dslot = 1; btarget = 32'h0000_c100; step("R6");
      mmu = 1; dslot = 1; bimm = 1; m_miss = 1; step("R6");
      mmu = 1; m_store = 1; mmu_addr = 32'hdead_0004; step("R7");
      mmu = 1; m_miss = 1; m_store = 1; step("R7");
      mmu = 1; m_miss = 1; m_fetch = 1; msr = 32'h0000_2a02; step("R7");

      // R12 priority
      msr = 32'h0000_0002; mmu = 1; hwx = 1; brk = 1; irq = 1; step("R12");
      hwx = 1; hwx_code = 5'd9; brk = 1; irq = 1; step("R12");
      brk = 1; irq = 1; step("R12");

      // R5 hardware exception alone reaches only the enabled instance
      msr = 32'h0000_0000; hwx = 1; hwx_code = 5'd4; step("R5");

      // R10 idle cycles
      repeat (3) step("R10");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule